// File: doc/BRIEF.md
# Duration-Driven Toggle Waveform Generator

This block produces an on/off keyed line from a stream of records, each carrying a level and a duration. The timer ticks once every `TICK_DIV` clocks, which gives one tick per microsecond at 64 MHz with the default of 64. The duration of each period is taken from a queue of slots. At every period boundary the line toggles and the next queued duration is loaded. Because the line only toggles, a slot's position fixes its level: data slots are numbered from 1, odd slots are high and even slots are low. When a record asks for a level that does not match the next slot, the block inserts a guard slot of fixed length first, which restores the alternation.

A run begins with a start request, which is honoured only while the transmit-permit input is high. The run opens with a quiet low period of `FIRST_LEN` ticks. It ends with an end-of-stream record, which queues a zero-length slot. The first boundary that loads the zero moves the block into a last state and stops slot fetching. The next boundary forces the line low, freezes the timer and raises done. While slots are queued, the block sums the durations of level slots and guard slots into separate high and low totals, so the duty cycle can be computed as high / (high + low).

Top module: `wg_wavegen`

## Requirements
- R1: After reset the line and its mirror are low, busy and done are low, both totals are zero, and the record-ready output stays low even with a record offered.
- R2: A start request seen while transmit-permit is low starts nothing; start_reject goes high for exactly the one cycle after the request and busy stays low. A start with permit is honoured only when idle or done.
- R3: After an honoured start the line is low for FIRST_LEN ticks (one tick = TICK_DIV clocks); its first rising edge comes exactly FIRST_LEN*TICK_DIV clocks after the start edge.
- R4: At each period boundary the line toggles, and the next period lasts as many ticks as the next queued slot (a zero slot lasts one tick), so edge-to-edge spacing is duration*TICK_DIV clocks.
- R5: A level record (kind 0) whose level matches the next slot's parity fills exactly one slot. The first data slot is odd (high), and parity alternates with each slot.
- R6: A level record whose level does not match the next slot's parity is preceded by one guard slot of GUARD_LEN ticks. The record is held and placed in the slot after the guard.
- R7: A wait record (kind 1) fills one GUARD_LEN slot, whatever its level field says.
- R8: A level record with zero duration is consumed without producing a slot, a parity change or any change to the totals.
- R9: An end-of-stream record (kind 2) queues a zero slot, and record-ready stays low from then on. The boundary that loads the zero enters the last state. The next boundary, one tick later, raises done, forces the line low and stops the timer.
- R10: Level and guard slots add their duration to the high total when odd and to the low total when even. Wait and end slots add nothing. Both totals clear on an honoured start.
- R11: If no slot is queued when a period would end, the line holds its level until one arrives, and the new period then runs its full length.
- R12: A stop request returns the block to idle on the next clock, with the line low, and refuses further records.
- R13: When MIRROR_EN is set, the mirror output always equals the line output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| stop_i | input | 1 | Abort the run and return to idle |
| tx_permit_i | input | 1 | Transmission allowed; a start is rejected without it |
| start_reject_o | output | 1 | One-cycle pulse after a start refused for lack of permit |
| rec_valid_i | input | 1 | A record is offered |
| rec_kind_i | input | 2 | Record kind: 0 level, 1 wait, 2 end of stream |
| rec_level_i | input | 1 | Requested level for a level record |
| rec_dur_i | input | DUR_W | Duration in ticks for a level record |
| rec_ready_o | output | 1 | Record accepted at this clock edge |
| wave_o | output | 1 | Keyed output line |
| mirror_o | output | 1 | Copy of the line for observation |
| busy_o | output | 1 | A run is in progress or has finished without being restarted |
| done_o | output | 1 | The run has ended, the line is low and the timer is frozen |
| high_total_o | output | TOT_W | Sum of ticks in odd slots |
| low_total_o | output | TOT_W | Sum of ticks in even slots |

## Verification
A rejected start shows on start_reject one clock later. A stop shows on busy and the line one clock later. The first edge of a run is due exactly FIRST_LEN*TICK_DIV clocks after the start edge, and each later edge is due duration*TICK_DIV clocks after the one before it. The bench timestamps every line change at the falling edge and compares the spacings, which makes these checks independent of how records and slots are queued. Done must still be low TICK_DIV-1 clocks after the final toggle and high one clock later, and the bench samples both of those cycles. When the bench starves the queue, it checks only the held level and the spacing after the queue recovers, because the stall length depends on when the record arrives.

// File: rtl/wg_pkg.sv
package wg_pkg;

    typedef enum logic [1:0] {
        KIND_LEVEL = 2'd0,
        KIND_WAIT  = 2'd1,
        KIND_END   = 2'd2,
        KIND_SPARE = 2'd3
    } rec_kind_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_RUN  = 2'd1,
        TX_LAST = 2'd2,
        TX_DONE = 2'd3
    } tx_state_e;

endpackage

// File: rtl/wg_slot_packer.sv
// Turns records into timer slots: tracks slot parity, inserts guard slots,
// drops empty level records and keeps the high/low tick totals.
module wg_slot_packer
    import wg_pkg::*;
#(
    parameter int DUR_W     = 16,
    parameter int TOT_W     = 32,
    parameter int GUARD_LEN = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             halt_i,
    input  logic             rec_valid_i,
    input  logic [1:0]       rec_kind_i,
    input  logic             rec_level_i,
    input  logic [DUR_W-1:0] rec_dur_i,
    input  logic             slot_room_i,
    output logic             rec_ready_o,
    output logic             slot_push_o,
    output logic [DUR_W-1:0] slot_dur_o,
    output logic [TOT_W-1:0] high_total_o,
    output logic [TOT_W-1:0] low_total_o
);
    localparam logic [DUR_W-1:0] GUARD = DUR_W'(GUARD_LEN);

    typedef struct packed {
        logic             run;
        logic             odd;
        logic [TOT_W-1:0] hi;
        logic [TOT_W-1:0] lo;
    } pk_t;

    pk_t              pk_d, pk_q;
    logic [DUR_W-1:0] emit_d;
    logic             emit_v;
    logic             take;
    logic             counted;

    always_comb begin
        pk_d    = pk_q;
        emit_d  = '0;
        emit_v  = 1'b0;
        take    = 1'b0;
        counted = 1'b0;
        if (pk_q.run && rec_valid_i && slot_room_i) begin
            case (rec_kind_e'(rec_kind_i))
                KIND_LEVEL: begin
                    if (rec_dur_i == '0) begin
                        take = 1'b1;                      // R8 dropped
                    end else if (rec_level_i != pk_q.odd) begin
                        emit_d  = GUARD;                  // R6 record held
                        emit_v  = 1'b1;
                        counted = 1'b1;
                    end else begin
                        emit_d  = rec_dur_i;
                        emit_v  = 1'b1;
                        counted = 1'b1;
                        take    = 1'b1;
                    end
                end
                KIND_END: begin
                    emit_d   = '0;
                    emit_v   = 1'b1;
                    take     = 1'b1;
                    pk_d.run = 1'b0;
                end
                default: begin
                    emit_d = GUARD;                       // wait slot, uncounted
                    emit_v = 1'b1;
                    take   = 1'b1;
                end
            endcase
        end
        if (emit_v) pk_d.odd = ~pk_q.odd;
        if (counted) begin
            if (pk_q.odd) pk_d.hi = pk_q.hi + TOT_W'(emit_d);
            else          pk_d.lo = pk_q.lo + TOT_W'(emit_d);
        end
        if (halt_i) pk_d.run = 1'b0;
        if (arm_i) begin
            pk_d.run = 1'b1;
            pk_d.odd = 1'b1;
            pk_d.hi  = '0;
            pk_d.lo  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign rec_ready_o  = take && !halt_i;
    assign slot_push_o  = emit_v && !halt_i;
    assign slot_dur_o   = emit_d;
    assign high_total_o = pk_q.hi;
    assign low_total_o  = pk_q.lo;

endmodule

// File: rtl/wg_slot_fifo.sv
// Small queue of slot durations between packer and timer.
module wg_slot_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         push_i,
    input  logic [W-1:0] push_dat_i,
    input  logic         pop_i,
    output logic [W-1:0] pop_dat_o,
    output logic         empty_o,
    output logic         room_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } ff_t;

    ff_t  ff_d, ff_q;
    logic do_push, do_pop;

    assign empty_o   = (ff_q.cnt == '0);
    assign room_o    = (ff_q.cnt != CNT_W'(DEPTH));
    assign pop_dat_o = ff_q.mem[ff_q.rp];

    always_comb begin
        ff_d    = ff_q;
        do_push = push_i && room_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            ff_d.mem[ff_q.wp] = push_dat_i;
            ff_d.wp = (ff_q.wp == LAST_PTR) ? '0 : ff_q.wp + PTR_W'(1);
        end
        if (do_pop) begin
            ff_d.rp = (ff_q.rp == LAST_PTR) ? '0 : ff_q.rp + PTR_W'(1);
        end
        case ({do_push, do_pop})
            2'b10:   ff_d.cnt = ff_q.cnt + CNT_W'(1);
            2'b01:   ff_d.cnt = ff_q.cnt - CNT_W'(1);
            default: ff_d.cnt = ff_q.cnt;
        endcase
        if (clear_i) begin
            ff_d.wp  = '0;
            ff_d.rp  = '0;
            ff_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

endmodule

// File: rtl/wg_period_timer.sv
// Tick prescaler, period down-counter with a one-deep preload, output
// toggle and the two-stage termination.
module wg_period_timer
    import wg_pkg::*;
#(
    parameter int DUR_W     = 16,
    parameter int TICK_DIV  = 64,
    parameter int FIRST_LEN = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             slot_avail_i,
    input  logic [DUR_W-1:0] slot_dur_i,
    output logic             slot_pop_o,
    output logic             wave_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int FL_W  = $clog2(FIRST_LEN + 1);
    localparam int REM_W = (FL_W > DUR_W) ? FL_W : DUR_W;
    localparam logic [DIV_W-1:0] PRE_TOP = DIV_W'(TICK_DIV - 1);

    typedef struct packed {
        tx_state_e        st;
        logic [DIV_W-1:0] pre;
        logic [REM_W-1:0] rem;
        logic [DUR_W-1:0] nxt;
        logic             nxt_vld;
        logic             wave;
    } tm_t;

    tm_t  tm_d, tm_q;
    logic running, tick, boundary;

    always_comb begin
        tm_d       = tm_q;
        slot_pop_o = 1'b0;
        running    = (tm_q.st == TX_RUN) || (tm_q.st == TX_LAST);
        tick       = running && (tm_q.pre == PRE_TOP);
        boundary   = tick && (tm_q.rem <= REM_W'(1)) &&
                     (tm_q.nxt_vld || tm_q.st == TX_LAST);

        if (running) tm_d.pre = tick ? '0 : tm_q.pre + DIV_W'(1);
        if (tick && tm_q.rem > REM_W'(1)) tm_d.rem = tm_q.rem - REM_W'(1);

        if (boundary) begin
            if (tm_q.st == TX_LAST) begin
                tm_d.st   = TX_DONE;
                tm_d.wave = 1'b0;
            end else begin
                tm_d.wave    = ~tm_q.wave;
                tm_d.rem     = REM_W'(tm_q.nxt);
                tm_d.nxt_vld = 1'b0;
                if (tm_q.nxt == '0) tm_d.st = TX_LAST;
            end
        end

        if (tm_q.st == TX_RUN && !tm_q.nxt_vld && slot_avail_i) begin
            slot_pop_o   = 1'b1;
            tm_d.nxt     = slot_dur_i;
            tm_d.nxt_vld = 1'b1;
        end

        if (start_i) begin
            tm_d.st      = TX_RUN;
            tm_d.pre     = '0;
            tm_d.rem     = REM_W'(FIRST_LEN);
            tm_d.nxt_vld = 1'b0;
            tm_d.wave    = 1'b0;
        end
        if (stop_i) begin
            tm_d.st      = TX_IDLE;
            tm_d.pre     = '0;
            tm_d.nxt_vld = 1'b0;
            tm_d.wave    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign wave_o = tm_q.wave;
    assign busy_o = (tm_q.st != TX_IDLE);
    assign done_o = (tm_q.st == TX_DONE);

endmodule

// File: rtl/wg_wavegen.sv
module wg_wavegen #(
    parameter int TICK_DIV   = 64,
    parameter int FIRST_LEN  = 1000,
    parameter int GUARD_LEN  = 50,
    parameter int DUR_W      = 16,
    parameter int TOT_W      = 32,
    parameter int SLOT_DEPTH = 4,
    parameter bit MIRROR_EN  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tx_permit_i,
    output logic             start_reject_o,
    input  logic             rec_valid_i,
    input  logic [1:0]       rec_kind_i,
    input  logic             rec_level_i,
    input  logic [DUR_W-1:0] rec_dur_i,
    output logic             rec_ready_o,
    output logic             wave_o,
    output logic             mirror_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [TOT_W-1:0] high_total_o,
    output logic [TOT_W-1:0] low_total_o
);
    typedef struct packed {
        logic reject;
    } top_t;

    top_t             top_d, top_q;
    logic             startable, accept;
    logic             push, pop, room, empty;
    logic [DUR_W-1:0] push_dur, head_dur;

    always_comb begin
        startable    = !busy_o || done_o;
        accept       = start_i && tx_permit_i && !stop_i && startable;
        top_d        = top_q;
        top_d.reject = start_i && !tx_permit_i && !stop_i && startable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign start_reject_o = top_q.reject;

    wg_slot_packer #(
        .DUR_W(DUR_W), .TOT_W(TOT_W), .GUARD_LEN(GUARD_LEN)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .arm_i(accept), .halt_i(stop_i),
        .rec_valid_i(rec_valid_i), .rec_kind_i(rec_kind_i),
        .rec_level_i(rec_level_i), .rec_dur_i(rec_dur_i),
        .slot_room_i(room), .rec_ready_o(rec_ready_o),
        .slot_push_o(push), .slot_dur_o(push_dur),
        .high_total_o(high_total_o), .low_total_o(low_total_o)
    );

    wg_slot_fifo #(
        .W(DUR_W), .DEPTH(SLOT_DEPTH)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear_i(accept || stop_i),
        .push_i(push), .push_dat_i(push_dur), .pop_i(pop),
        .pop_dat_o(head_dur), .empty_o(empty), .room_o(room)
    );

    wg_period_timer #(
        .DUR_W(DUR_W), .TICK_DIV(TICK_DIV), .FIRST_LEN(FIRST_LEN)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .start_i(accept), .stop_i(stop_i),
        .slot_avail_i(!empty), .slot_dur_i(head_dur), .slot_pop_o(pop),
        .wave_o(wave_o), .busy_o(busy_o), .done_o(done_o)
    );

    generate
        if (MIRROR_EN) begin : g_mirror
            assign mirror_o = wave_o;
        end else begin : g_no_mirror
            assign mirror_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/wg_wavegen_chk.sv
module wg_wavegen_chk #(
    parameter int TOT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic             start_reject_o,
    input logic             rec_ready_o,
    input logic             wave_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [TOT_W-1:0] high_total_o
);
    // R2: a refused start never leaves a fresh run behind
    a_r2_reject_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        start_reject_o |-> (!busy_o || done_o));

    // R9: finished run keeps the line low
    a_r9_done_low: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wave_o);

    // R9: no record is taken once the run is over
    a_r9_no_refill: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rec_ready_o);

    // R12: stop lands in idle with the line low
    a_r12_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!busy_o && !wave_o));

    // R4: the line only moves while a run is under way
    a_r4_edge_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wave_o) |-> $past(busy_o));

    // R10: high total never shrinks within one run
    a_r10_total_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(start_i)) |->
            (high_total_o >= $past(high_total_o)));
endmodule

bind wg_wavegen wg_wavegen_chk #(.TOT_W(TOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .start_reject_o(start_reject_o), .rec_ready_o(rec_ready_o),
    .wave_o(wave_o), .busy_o(busy_o), .done_o(done_o),
    .high_total_o(high_total_o)
);

// File: tb/sim_wg_wavegen.sv
`timescale 1ns/1ps
module sim_wg_wavegen;
    localparam int DIV = 4;
    localparam int FL  = 6;
    localparam int GD  = 3;

    // {kind[1:0], level, duration[7:0]}
    localparam logic [10:0] STREAM [0:8] = '{
        {2'd0, 1'b1, 8'd6}, {2'd0, 1'b0, 8'd3}, {2'd0, 1'b0, 8'd2},
        {2'd1, 1'b0, 8'd0}, {2'd0, 1'b0, 8'd5}, {2'd0, 1'b1, 8'd0},
        {2'd0, 1'b1, 8'd2}, {2'd0, 1'b1, 8'd4}, {2'd2, 1'b0, 8'd0}
    };
    // expected interval lengths in ticks between successive line changes
    localparam int EXP_IV [0:9] = '{FL, 6, 3, GD, 2, GD, 5, 2, GD, 4};
    localparam int EXP_HI = 15;
    localparam int EXP_LO = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, tx_permit_i = 1'b0;
    logic        rec_valid_i = 1'b0, rec_level_i = 1'b0;
    logic [1:0]  rec_kind_i = 2'd0;
    logic [15:0] rec_dur_i = 16'd0;
    logic        start_reject_o, rec_ready_o, wave_o, mirror_o, busy_o, done_o;
    logic [31:0] high_total_o, low_total_o;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, start_cyc = 0, n_edges = 0;
    int edge_t [0:31];
    bit mon_on = 1'b0;
    logic mon_prev = 1'b0;

    wg_wavegen #(.TICK_DIV(DIV), .FIRST_LEN(FL), .GUARD_LEN(GD)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .tx_permit_i(tx_permit_i), .start_reject_o(start_reject_o),
        .rec_valid_i(rec_valid_i), .rec_kind_i(rec_kind_i),
        .rec_level_i(rec_level_i), .rec_dur_i(rec_dur_i),
        .rec_ready_o(rec_ready_o), .wave_o(wave_o), .mirror_o(mirror_o),
        .busy_o(busy_o), .done_o(done_o),
        .high_total_o(high_total_o), .low_total_o(low_total_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mon_on && wave_o !== mon_prev) begin
            if (n_edges < 32) edge_t[n_edges] = cyc;
            n_edges = n_edges + 1;
        end
        mon_prev = wave_o;
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual run still going, expected finish");
        summary();
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic send_rec(input logic [1:0] k, input logic l, input logic [7:0] du);
        rec_kind_i = k; rec_level_i = l; rec_dur_i = 16'(du); rec_valid_i = 1'b1;
        #1;
        while (!rec_ready_o) begin
            @(negedge clk); #1;
        end
        step();
        rec_valid_i = 1'b0;
    endtask

    task automatic do_start();
        n_edges = 0;
        mon_prev = wave_o;
        mon_on = 1'b1;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        start_cyc = cyc;
    endtask

    function automatic string iv_tag(input int k);
        case (k)
            0:       return "R3 startup";
            1, 2:    return "R5 matching level";
            3, 4:    return "R6 guard then record";
            5:       return "R7 wait slot";
            7:       return "R8 after dropped record";
            8:       return "R6 guard before high";
            default: return "R4 slot spacing";
        endcase
    endfunction

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 wave", wave_o, 0);
        chk("R1 mirror", mirror_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 high total", high_total_o, 0);
        chk("R1 low total", low_total_o, 0);
        rec_valid_i = 1'b1; #1;
        chk("R1 ready idle", rec_ready_o, 0);
        rec_valid_i = 1'b0;

        // R2 refused start
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        chk("R2 reject pulse", start_reject_o, 1);
        chk("R2 busy stays low", busy_o, 0);
        step();
        chk("R2 pulse one cycle", start_reject_o, 0);
        chk("R2 still idle", busy_o, 0);

        // main stream walked from the table
        tx_permit_i = 1'b1;
        do_start();
        for (int i = 0; i < 9; i++)
            send_rec(STREAM[i][10:9], STREAM[i][8], STREAM[i][7:0]);
        while (n_edges < 10) step();
        for (int k = 0; k < 10; k++) begin
            int prev;
            prev = (k == 0) ? start_cyc : edge_t[k-1];
            chk(iv_tag(k), edge_t[k] - prev, EXP_IV[k] * DIV);
        end
        repeat (DIV - 1) step();
        chk("R9 done not yet", done_o, 0);
        step();
        chk("R9 done one tick after final toggle", done_o, 1);
        chk("R9 line low at end", wave_o, 0);
        chk("R10 high total", high_total_o, EXP_HI);
        chk("R10 low total", low_total_o, EXP_LO);
        rec_valid_i = 1'b1; rec_kind_i = 2'd0; rec_level_i = 1'b1; rec_dur_i = 16'd3;
        #1;
        chk("R9 no refill after end", rec_ready_o, 0);
        rec_valid_i = 1'b0;
        repeat (8) step();
        chk("R9 timer frozen", n_edges, 10);

        // R11 starved queue, restart from done
        do_start();
        chk("R10 totals cleared on start", high_total_o + low_total_o, 0);
        repeat (FL * DIV + 8) step();
        chk("R11 level held while starved", wave_o, 0);
        chk("R11 no edge while starved", n_edges, 0);
        send_rec(2'd0, 1'b1, 8'd2);
        send_rec(2'd2, 1'b0, 8'd0);
        while (n_edges < 2) step();
        chk("R11 late edge", (edge_t[0] - start_cyc) > FL * DIV, 1);
        chk("R11 full period after stall", edge_t[1] - edge_t[0], 2 * DIV);
        while (!done_o) step();

        // R12 stop, R13 mirror
        do_start();
        send_rec(2'd0, 1'b1, 8'd20);
        send_rec(2'd0, 1'b0, 8'd5);
        while (n_edges < 1) step();
        repeat (5) step();
        chk("R5 first slot high", wave_o, 1);
        chk("R13 mirror high", mirror_o, 1);
        chk("R12 busy before stop", busy_o, 1);
        stop_i = 1'b1;
        step();
        stop_i = 1'b0;
        chk("R12 idle after stop", busy_o, 0);
        chk("R12 line low after stop", wave_o, 0);
        chk("R13 mirror follows", mirror_o, 0);
        rec_valid_i = 1'b1; #1;
        chk("R12 records refused", rec_ready_o, 0);
        rec_valid_i = 1'b0;
        repeat (30) step();
        chk("R12 no toggles after stop", n_edges, 2);

        summary();
        $finish;
    end
endmodule